// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. The page size is 4 KiB. The walker splits the address into three fields: a 10-bit outer index in bits 31..22, a 10-bit inner index in bits 21..12, and a 12-bit page offset in bits 11..0. The walk makes one or two dependent reads through a single 32-bit memory read port. The outer entry gives the frame that holds the inner table. The inner entry gives the frame that the access lands in.

A request carries three inputs: the virtual address, an access type, and a one-cycle strobe. With it come the table base and the table length, which the walker latches when it accepts the request. The walker checks the outer index against the table length before any memory traffic. It checks the valid bit of both entries, and the permission bits of the final entry. It ends the walk with a one-cycle done pulse that carries the physical address, or a one-cycle fault pulse that carries a cause code. The table entry layout is as follows:

- bits 31..12: frame number
- bit 0: valid (V)
- bit 1: read (R)
- bit 2: write (W)
- bit 3: execute (X)
- bits 11..4: reserved

Top module: `pt_walker`

## Requirements
- R1: The outer read address is the latched table base plus 4 times the outer index (virtual address bits 31..22).
- R2: An outer index greater than or equal to the table length raises fault_o with cause 1 in the cycle after the request is accepted, with no memory read. An index of length minus one walks normally.
- R3: The inner read address is the outer entry's bits 31..12 followed by twelve zero bits, plus 4 times the inner index (virtual address bits 21..12).
- R4: An outer entry whose bit 0 (valid) is clear faults with cause 2, and no inner read is issued.
- R5: An inner entry whose bit 0 (valid) is clear faults with cause 3.
- R6: The access type is encoded as follows, and a denied access faults with cause 4:
  - 0 (read) needs inner entry bit 1.
  - 1 (write) needs inner entry bit 2.
  - 2 (execute) needs inner entry bit 3.
  - 3 is never permitted.
  - The permission bits of the outer entry are ignored.
- R7: On success, done_o pulses and paddr_o holds the inner entry's bits 31..12 joined with the unchanged 12-bit offset.
- R8: done_o and fault_o are never high together, and each response lasts exactly one cycle.
- R9: A request is accepted only while the walker is idle. A strobe while busy_o is high has no effect on the walk in progress, and does not cause a second response.
- R10: mem_rd_req_o stays high with a stable address until mem_rd_valid_i is seen. The entry is taken from mem_rd_data_i in that cycle.
- R11: After reset, busy_o, mem_rd_req_o, done_o and fault_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr_i | input | 32 | Byte address of the outer table |
| ptlr_i | input | 11 | Number of usable outer entries |
| mem_rd_req_o | output | 1 | Memory read request, held until valid |
| mem_rd_addr_o | output | 32 | Byte address of the table entry to read |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 32 | Table entry read from memory |
| busy_o | output | 1 | Walk in progress; new requests are ignored |
| done_o | output | 1 | One-cycle successful-translation pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_cause_o | output | 3 | 0 none, 1 length, 2 outer invalid, 3 inner invalid, 4 permission |
| paddr_o | output | 32 | Physical address, valid with done_o |

## Verification
A wrong walk state shows at the ports within one memory handshake, and each kind of error shows up differently:

- A state that skips the outer read shows a wrong number of reads.
- A latched base or frame that is not captured shows a wrong read address at the next mem_rd_req_o.
- A misplaced permission or valid bit shows as a wrong cause code, or as a done where a fault was due, in the single response cycle.

Every walk also checks that the response falls back to low one cycle later, and that a length fault answers in exactly one cycle with no read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_LENGTH  = 3'd1,
    CAUSE_OUT_INV = 3'd2,
    CAUSE_IN_INV  = 3'd3,
    CAUSE_PERM    = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;

  // bit positions inside a table entry
  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_R = 1;
  localparam int unsigned PTE_W = 2;
  localparam int unsigned PTE_X = 3;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned AW        = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic [AW-1:0]       vaddr_i,
  input  logic [AW-1:0]       tbase_i,
  input  logic [AW-OFF_W-1:0] inner_frame_i,
  input  logic                inner_sel_i,
  output logic [AW-1:0]       rd_addr_o
);
  localparam int unsigned SHIFT   = $clog2(PTE_BYTES);
  localparam int unsigned OUT_LSB = OFF_W + IDX_W;

  logic [IDX_W-1:0] outer_idx, inner_idx;
  logic [AW-1:0]    outer_addr, inner_addr, inner_base;

  always_comb begin
    outer_idx  = vaddr_i[OUT_LSB +: IDX_W];
    inner_idx  = vaddr_i[OFF_W +: IDX_W];
    inner_base = {inner_frame_i, {OFF_W{1'b0}}};
    outer_addr = tbase_i    + (AW'(outer_idx) << SHIFT);
    inner_addr = inner_base + (AW'(inner_idx) << SHIFT);
    rd_addr_o  = inner_sel_i ? inner_addr : outer_addr;
  end
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
(
  input  logic [PTE_X:0] pte_flags_i,
  input  acc_e           acc_i,
  output logic           present_o,
  output logic           allow_o
);
  always_comb begin
    present_o = pte_flags_i[PTE_V];
    unique case (acc_i)
      ACC_READ:  allow_o = pte_flags_i[PTE_R];
      ACC_WRITE: allow_o = pte_flags_i[PTE_W];
      ACC_EXEC:  allow_o = pte_flags_i[PTE_X];
      default:   allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [AW-1:0]       vaddr_i,
  input  acc_e                acc_i,
  input  logic [AW-1:0]       tbase_i,
  input  logic [IDX_W:0]      tlen_i,
  input  logic                rd_valid_i,
  input  logic [AW-OFF_W-1:0] rd_frame_i,
  input  logic                pte_present_i,
  input  logic                pte_allow_i,
  output logic                rd_req_o,
  output logic                inner_sel_o,
  output logic [AW-1:0]       vaddr_q_o,
  output logic [AW-1:0]       tbase_q_o,
  output logic [AW-OFF_W-1:0] iframe_q_o,
  output acc_e                acc_q_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fault_o,
  output cause_e              cause_o,
  output logic [AW-1:0]       paddr_o
);
  localparam int unsigned FR_W    = AW - OFF_W;
  localparam int unsigned OUT_LSB = OFF_W + IDX_W;

  walk_st_e          state_q, state_d;
  logic [AW-1:0]     vaddr_q, tbase_q, paddr_q, paddr_d;
  logic [FR_W-1:0]   iframe_q;
  acc_e              acc_q;
  cause_e            cause_q, cause_d;
  logic              accept, in_range;
  logic              en_req, en_iframe, en_paddr, en_cause;

  assign in_range = {1'b0, vaddr_i[OUT_LSB +: IDX_W]} < tlen_i;
  assign accept   = (state_q == ST_IDLE) && req_i;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cause_d   = cause_q;
    paddr_d   = paddr_q;
    en_req    = 1'b0;
    en_iframe = 1'b0;
    en_paddr  = 1'b0;
    en_cause  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          en_req   = 1'b1;
          en_cause = 1'b1;
          if (in_range) begin
            cause_d = CAUSE_NONE;
            state_d = ST_OUTER;
          end else begin
            cause_d = CAUSE_LENGTH;
            state_d = ST_RESP;
          end
        end
      end
      ST_OUTER: begin
        if (rd_valid_i) begin
          if (pte_present_i) begin
            en_iframe = 1'b1;
            state_d   = ST_INNER;
          end else begin
            en_cause = 1'b1;
            cause_d  = CAUSE_OUT_INV;
            state_d  = ST_RESP;
          end
        end
      end
      ST_INNER: begin
        if (rd_valid_i) begin
          en_cause = 1'b1;
          state_d  = ST_RESP;
          if (!pte_present_i) begin
            cause_d = CAUSE_IN_INV;
          end else if (!pte_allow_i) begin
            cause_d = CAUSE_PERM;
          end else begin
            cause_d  = CAUSE_NONE;
            en_paddr = 1'b1;
            paddr_d  = {rd_frame_i, vaddr_q[OFF_W-1:0]};
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      vaddr_q  <= '0;
      tbase_q  <= '0;
      acc_q    <= ACC_READ;
      iframe_q <= '0;
      paddr_q  <= '0;
      cause_q  <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      if (en_req) begin
        vaddr_q <= vaddr_i;
        tbase_q <= tbase_i;
        acc_q   <= acc_i;
      end
      if (en_iframe) iframe_q <= rd_frame_i;
      if (en_paddr)  paddr_q  <= paddr_d;
      if (en_cause)  cause_q  <= cause_d;
    end
  end

  assign rd_req_o    = (state_q == ST_OUTER) || (state_q == ST_INNER);
  assign inner_sel_o = (state_q == ST_INNER);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_RESP) && (cause_q == CAUSE_NONE);
  assign fault_o     = (state_q == ST_RESP) && (cause_q != CAUSE_NONE);
  assign cause_o     = fault_o ? cause_q : CAUSE_NONE;
  assign paddr_o     = paddr_q;
  assign vaddr_q_o   = vaddr_q;
  assign tbase_q_o   = tbase_q;
  assign iframe_q_o  = iframe_q;
  assign acc_q_o     = acc_q;

  AST_LEN_FAULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> (fault_o && cause_o == CAUSE_LENGTH && !rd_req_o)); // R2
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |=> !(done_o || fault_o)); // R8
  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o})); // R8
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i && !(done_o || fault_o)) |=> busy_o); // R9
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [AW-1:0]    req_vaddr_i,
  input  logic [1:0]       req_acc_i,
  input  logic [AW-1:0]    ptbr_i,
  input  logic [IDX_W:0]   ptlr_i,
  output logic             mem_rd_req_o,
  output logic [AW-1:0]    mem_rd_addr_o,
  input  logic             mem_rd_valid_i,
  input  logic [AW-1:0]    mem_rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [2:0]       fault_cause_o,
  output logic [AW-1:0]    paddr_o
);
  localparam int unsigned FR_W = AW - OFF_W;

  logic            rst_n_s;
  logic            inner_sel, present, allow;
  logic [AW-1:0]   vaddr_q, tbase_q;
  logic [FR_W-1:0] iframe_q;
  acc_e            acc_q;
  cause_e          cause;

  ptw_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  ptw_ctrl #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_i         (req_i),
    .vaddr_i       (req_vaddr_i),
    .acc_i         (acc_e'(req_acc_i)),
    .tbase_i       (ptbr_i),
    .tlen_i        (ptlr_i),
    .rd_valid_i    (mem_rd_valid_i),
    .rd_frame_i    (mem_rd_data_i[AW-1:OFF_W]),
    .pte_present_i (present),
    .pte_allow_i   (allow),
    .rd_req_o      (mem_rd_req_o),
    .inner_sel_o   (inner_sel),
    .vaddr_q_o     (vaddr_q),
    .tbase_q_o     (tbase_q),
    .iframe_q_o    (iframe_q),
    .acc_q_o       (acc_q),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .cause_o       (cause),
    .paddr_o       (paddr_o)
  );

  ptw_addr_gen #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)) i_addr_gen (
    .vaddr_i       (vaddr_q),
    .tbase_i       (tbase_q),
    .inner_frame_i (iframe_q),
    .inner_sel_i   (inner_sel),
    .rd_addr_o     (mem_rd_addr_o)
  );

  ptw_entry_chk i_entry_chk (
    .pte_flags_i (mem_rd_data_i[PTE_X:0]),
    .acc_i       (acc_q),
    .present_o   (present),
    .allow_o     (allow)
  );

  assign fault_cause_o = cause;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_rd_req_o && !mem_rd_valid_i) |=> (mem_rd_req_o && $stable(mem_rd_addr_o))); // R10
  AST_DONE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> (paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy_o) |-> (!mem_rd_req_o && !done_o && !fault_o)); // R11
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc = '0;
  logic [31:0] ptbr = 32'h0000_1000;
  logic [10:0] ptlr = 11'd3;
  logic        mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_data = '0;
  logic        busy, done, fault;
  logic [2:0]  cause;
  logic [31:0] paddr;

  int          compared = 0, mismatched = 0;
  int          lat = 0, cnt = 0, nreads = 0;
  logic [31:0] log_prev = '0, log_last = '0;
  logic [31:0] mem [0:4095];

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_vaddr_i(vaddr), .req_acc_i(acc),
    .ptbr_i(ptbr), .ptlr_i(ptlr), .mem_rd_req_o(mem_req), .mem_rd_addr_o(mem_addr),
    .mem_rd_valid_i(mem_valid), .mem_rd_data_i(mem_data), .busy_o(busy),
    .done_o(done), .fault_o(fault), .fault_cause_o(cause), .paddr_o(paddr)
  );

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (a[31:14] != 18'd0) return 32'h0;
    return mem[a[13:2]];
  endfunction

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
      cnt <= 0;
    end else if (mem_req) begin
      if (cnt == lat) begin
        mem_valid <= 1'b1;
        mem_data  <= rd_word(mem_addr);
        log_prev  <= log_last;
        log_last  <= mem_addr;
        nreads    <= nreads + 1;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  function automatic logic [31:0] va(input int o, input int i, input int off);
    return {o[9:0], i[9:0], off[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] a, input logic [1:0] t,
                      input logic exp_fault, input logic [2:0] exp_cause,
                      input logic [31:0] exp_pa, input int exp_reads,
                      input logic [31:0] exp_out_a, input logic [31:0] exp_in_a,
                      output int cycles);
    int r0;
    r0 = nreads;
    @(negedge clk);
    req = 1'b1; vaddr = a; acc = t;
    @(negedge clk);
    req = 1'b0;
    cycles = 1;
    while (!(done || fault) && cycles < 200) begin
      @(negedge clk);
      cycles++;
    end
    chk({tag, " R8 done"}, {31'd0, done}, {31'd0, !exp_fault});
    chk({tag, " R8 fault"}, {31'd0, fault}, {31'd0, exp_fault});
    chk({tag, " cause"}, {29'd0, cause}, {29'd0, exp_cause});
    if (!exp_fault) chk({tag, " R7 paddr"}, paddr, exp_pa);
    chk({tag, " reads"}, nreads - r0, exp_reads);
    if (exp_reads == 1) chk({tag, " R1 outer addr"}, log_last, exp_out_a);
    if (exp_reads == 2) begin
      chk({tag, " R1 outer addr"}, log_prev, exp_out_a);
      chk({tag, " R3 inner addr"}, log_last, exp_in_a);
    end
    @(negedge clk);
    chk({tag, " R8 single cycle"}, {31'd0, done || fault}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R11 busy", {31'd0, busy}, 0);
    chk("R11 mem req", {31'd0, mem_req}, 0);
    chk("R11 done/fault", {30'd0, done, fault}, 0);
  endtask

  task automatic t_success();
    int c;
    lat = 0;
    walk("R7 read", va(0,0,12'h123), 2'd0, 0, 0, 32'hABCDE123, 2, 32'h1000, 32'h2000, c);
    lat = 3;
    walk("R10 exec lat3", va(0,1,12'hFFF), 2'd2, 0, 0, 32'h12345FFF, 2, 32'h1000, 32'h2004, c);
    walk("R3 last inner", va(0,1023,0), 2'd1, 0, 0, 32'hFFFFF000, 2, 32'h1000, 32'h2FFC, c);
    lat = 1;
    walk("R1 outer idx1", va(1,0,12'hABC), 2'd1, 0, 0, 32'h00042ABC, 2, 32'h1004, 32'h3000, c);
  endtask

  task automatic t_length();
    int c;
    lat = 0;
    ptlr = 11'd3;
    walk("R2 length", va(3,0,0), 2'd0, 1, 3'd1, 0, 0, 0, 0, c);
    chk("R2 one-cycle answer", c, 1);
    ptlr = 11'd4;
    walk("R2 boundary", va(3,0,12'h010), 2'd0, 0, 0, 32'hABCDE010, 2, 32'h100C, 32'h2000, c);
    ptlr = 11'd3;
  endtask

  task automatic t_invalid();
    int c;
    lat = 2;
    walk("R4 outer invalid", va(2,0,0), 2'd0, 1, 3'd2, 0, 1, 32'h1008, 0, c);
    walk("R5 inner invalid", va(0,5,0), 2'd0, 1, 3'd3, 0, 2, 32'h1000, 32'h2014, c);
  endtask

  task automatic t_perm();
    int c;
    lat = 0;
    walk("R6 write denied", va(0,0,0), 2'd1, 1, 3'd4, 0, 2, 32'h1000, 32'h2000, c);
    walk("R6 exec only ok", va(0,7,12'h044), 2'd2, 0, 0, 32'h77777044, 2, 32'h1000, 32'h201C, c);
    walk("R6 read denied", va(0,7,0), 2'd0, 1, 3'd4, 0, 2, 32'h1000, 32'h201C, c);
    walk("R6 no-read page", va(1,0,0), 2'd0, 1, 3'd4, 0, 2, 32'h1004, 32'h3000, c);
    walk("R6 access 3", va(0,1,0), 2'd3, 1, 3'd4, 0, 2, 32'h1000, 32'h2004, c);
  endtask

  task automatic t_busy();
    int c, r0, resp;
    lat = 4;
    r0 = nreads;
    @(negedge clk);
    req = 1'b1; vaddr = va(0,0,12'h7A0); acc = 2'd0;
    @(negedge clk);
    vaddr = va(3,0,0);
    c = 1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    c = 4;
    while (!(done || fault) && c < 200) begin @(negedge clk); c++; end
    chk("R9 first walk done", {31'd0, done}, 1);
    chk("R9 first paddr", paddr, 32'hABCDE7A0);
    resp = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done || fault || busy) resp++;
    end
    chk("R9 no second response", resp, 0);
    chk("R9 reads", nreads - r0, 2);
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    mem[1024] = 32'h0000_2001;
    mem[1025] = 32'h0000_300F;
    mem[1026] = 32'h0000_300E;
    mem[1027] = 32'h0000_2001;
    mem[2048] = 32'hABCD_E003;
    mem[2049] = 32'h1234_500F;
    mem[2053] = 32'h5555_500E;
    mem[2055] = 32'h7777_7009;
    mem[3071] = 32'hFFFF_F007;
    mem[3072] = 32'h0004_2005;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_success();
    t_length();
    t_invalid();
    t_perm();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule